// File: doc/BRIEF.md
# SD Card Data Phase Sequencer

This block runs the data phase of an SD/MMC-style transfer. It sits between the register file and the line serializers and decides which phase the transfer is in. It also decides when the transfer ends and whether it ended cleanly. Software supplies three values:

- a byte length
- a data watchdog value
- an acknowledgment watchdog value

A start request then launches either a send or a receive. The serializer reports each byte moved with a one-cycle strobe. The block counts those strobes down from the programmed length. When the count reaches zero it returns to Idle and raises a sticky end-of-data flag.

Two independent down-counting watchdogs guard the waiting phases:

- The data watchdog runs while the controller waits for the card's start bit, and again while the card holds the line busy after a send.
- The acknowledgment watchdog runs only while the controller waits for a card acknowledgment after a receive that asked for one.

When either watchdog expires, the block returns to Idle and sets the matching sticky flag. An external error input also returns the block to Idle. Both the timeout and the error paths suppress the end-of-data flag. The remaining byte count and the current phase are exposed as registered outputs.

Top module: `sd_data_path_ctrl`

## Requirements
- R1: After synchronous reset, the phase output is Idle (code 0), the byte count is 0 and all three flags are 0. The phase codes are: Idle=0, WaitSend=1, Send=2, WaitRecv=3, Receive=4, Busy=5, WaitAck=6.
- R2: A start request seen in Idle loads the byte count from the length input. On the next cycle the phase becomes WaitRecv if the direction bit is 1, or WaitSend if it is 0. A start request in any other phase changes neither the phase nor the count.
- R3: WaitSend always moves to Send on the following cycle. In Send and Receive, each cycle with the byte strobe high lowers the count by one. A cycle without the strobe leaves the count unchanged.
- R4: On the strobe that takes the count from 1 to 0 in Send, the phase goes to Idle and the end flag is set if card busy is low. If card busy is high, the phase goes to Busy instead. Busy goes to Idle with the end flag set on the first cycle card busy is low.
- R5: WaitRecv moves to Receive on the cycle after the start-bit input is high. On the last byte of a receive without acknowledgment mode, the phase goes to Idle and the end flag is set.
- R6: On entering WaitRecv, the data watchdog is loaded with the data timeout value N. It is loaded again with N on entering Busy. If the phase stays in WaitRecv or Busy for N+1 cycles, the block returns to Idle with the data timeout flag set and the end flag not set.
- R7: A receive started with the acknowledgment bit set goes to WaitAck after its last byte, with the acknowledgment watchdog loaded with M. An acknowledgment pulse then returns the block to Idle and sets the end flag. If no pulse arrives within M+1 cycles, the block returns to Idle with the acknowledgment timeout flag set and the end flag not set.
- R8: The error input high in any phase other than Idle returns the block to Idle on the next cycle and sets no flag.
- R9: Each flag stays set until its own clear pulse. A clear pulse in the same cycle as a set condition leaves the flag set.
- R10: A start request with length 0 leaves the phase at Idle and sets the end flag on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len | input | LEN_W | Transfer length in bytes |
| cfg_dtime | input | TMR_W | Data watchdog reload value |
| cfg_atime | input | TMR_W | Acknowledgment watchdog reload value |
| start_req | input | 1 | Start a transfer (honoured only in Idle) |
| start_dir | input | 1 | 1 = receive, 0 = send |
| start_ack | input | 1 | Receive expects an acknowledgment afterwards |
| byte_stb | input | 1 | One byte moved on the bus |
| rx_start_bit | input | 1 | Start bit seen on the receive line |
| card_busy | input | 1 | Card holds the data line busy |
| ack_rcv | input | 1 | Acknowledgment received pulse |
| err_in | input | 1 | Transfer error, aborts to Idle |
| clr_end | input | 1 | Clear pulse for the end flag |
| clr_dto | input | 1 | Clear pulse for the data timeout flag |
| clr_ato | input | 1 | Clear pulse for the acknowledgment timeout flag |
| data_cnt | output | LEN_W | Bytes still to transfer |
| flag_end | output | 1 | Sticky clean end-of-data |
| flag_dto | output | 1 | Sticky data timeout |
| flag_ato | output | 1 | Sticky acknowledgment timeout |
| state_o | output | 3 | Current phase code |

## Verification
Every output is a register, so a wrong phase is visible on the phase output one cycle after the faulty decision. A miscounted byte shows up on the count output after the very strobe that caused it. A watchdog that is loaded or decremented in the wrong phase moves the return to Idle earlier or later than exactly N+1 cycles. The bench therefore checks the phase on every cycle of each timeout window. A flag raised or suppressed wrongly becomes visible on the cycle the block reaches Idle.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_WAIT_S   = 3'd1,
    PH_SEND     = 3'd2,
    PH_WAIT_R   = 3'd3,
    PH_RECV     = 3'd4,
    PH_BUSY     = 3'd5,
    PH_WAIT_ACK = 3'd6
  } phase_t;

  localparam int FLAG_END = 0;
  localparam int FLAG_DTO = 1;
  localparam int FLAG_ATO = 2;
  localparam int NUM_FLAGS = 3;
endpackage

// File: rtl/sdp_down_counter.sv
module sdp_down_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         is_zero
);
  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (dec && !is_zero) cnt <= cnt - 1'b1;
  end

  assign is_zero = (cnt == '0);
endmodule

// File: rtl/sdp_status_flags.sv
module sdp_status_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end

    // R9: a set condition beats a simultaneous clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> q[i]);
    // R9: a lone clear empties the flag
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !set[i]) |=> !q[i]);
    // R9: without a set the flag never rises
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
      (!set[i] && !q[i]) |=> !q[i]);
  end
endmodule

// File: rtl/sd_data_path_ctrl.sv
module sd_data_path_ctrl
  import sdp_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [TMR_W-1:0] cfg_dtime,
  input  logic [TMR_W-1:0] cfg_atime,
  input  logic             start_req,
  input  logic             start_dir,
  input  logic             start_ack,
  input  logic             byte_stb,
  input  logic             rx_start_bit,
  input  logic             card_busy,
  input  logic             ack_rcv,
  input  logic             err_in,
  input  logic             clr_end,
  input  logic             clr_dto,
  input  logic             clr_ato,
  output logic [LEN_W-1:0] data_cnt,
  output logic             flag_end,
  output logic             flag_dto,
  output logic             flag_ato,
  output logic [2:0]       state_o
);
  localparam logic [LEN_W-1:0] ONE_BYTE = LEN_W'(1);

  phase_t st_q, st_d;
  logic   ack_q, ack_d;

  logic byte_load, byte_dec, byte_zero;
  logic dt_load, dt_dec, dt_zero;
  logic at_load, at_dec, at_zero;
  logic [TMR_W-1:0] dt_cnt, at_cnt;
  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;
  logic byte_last;

  assign byte_last = byte_stb && (data_cnt == ONE_BYTE);

  // Phase sequencing
  always_comb begin
    st_d      = st_q;
    ack_d     = ack_q;
    byte_load = 1'b0;
    byte_dec  = 1'b0;
    dt_load   = 1'b0;
    dt_dec    = 1'b0;
    at_load   = 1'b0;
    at_dec    = 1'b0;
    flag_set  = '0;
    unique case (st_q)
      PH_IDLE: begin
        if (start_req) begin
          byte_load = 1'b1;
          dt_load   = 1'b1;
          ack_d     = start_ack;
          if (cfg_len == '0) flag_set[FLAG_END] = 1'b1;
          else               st_d = start_dir ? PH_WAIT_R : PH_WAIT_S;
        end
      end
      PH_WAIT_S: st_d = PH_SEND;
      PH_SEND: begin
        byte_dec = byte_stb;
        if (byte_last) begin
          if (card_busy) begin
            st_d    = PH_BUSY;
            dt_load = 1'b1;
          end else begin
            st_d = PH_IDLE;
            flag_set[FLAG_END] = 1'b1;
          end
        end
      end
      PH_WAIT_R: begin
        if (rx_start_bit) st_d = PH_RECV;
        else if (dt_zero) begin
          st_d = PH_IDLE;
          flag_set[FLAG_DTO] = 1'b1;
        end else dt_dec = 1'b1;
      end
      PH_RECV: begin
        byte_dec = byte_stb;
        if (byte_last) begin
          if (ack_q) begin
            st_d    = PH_WAIT_ACK;
            at_load = 1'b1;
          end else begin
            st_d = PH_IDLE;
            flag_set[FLAG_END] = 1'b1;
          end
        end
      end
      PH_BUSY: begin
        if (!card_busy) begin
          st_d = PH_IDLE;
          flag_set[FLAG_END] = 1'b1;
        end else if (dt_zero) begin
          st_d = PH_IDLE;
          flag_set[FLAG_DTO] = 1'b1;
        end else dt_dec = 1'b1;
      end
      PH_WAIT_ACK: begin
        if (ack_rcv) begin
          st_d = PH_IDLE;
          flag_set[FLAG_END] = 1'b1;
        end else if (at_zero) begin
          st_d = PH_IDLE;
          flag_set[FLAG_ATO] = 1'b1;
        end else at_dec = 1'b1;
      end
      default: st_d = PH_IDLE;
    endcase
    // Error abort overrides every other decision outside Idle
    if (st_q != PH_IDLE && err_in) begin
      st_d     = PH_IDLE;
      flag_set = '0;
      byte_dec = 1'b0;
      dt_load  = 1'b0;
      dt_dec   = 1'b0;
      at_load  = 1'b0;
      at_dec   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= PH_IDLE;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ack_q <= ack_d;
    end
  end

  sdp_down_counter #(.W(LEN_W)) u_byte_cnt (
    .clk(clk), .rst(rst), .load(byte_load), .load_val(cfg_len),
    .dec(byte_dec), .cnt(data_cnt), .is_zero(byte_zero)
  );

  sdp_down_counter #(.W(TMR_W)) u_data_wdog (
    .clk(clk), .rst(rst), .load(dt_load), .load_val(cfg_dtime),
    .dec(dt_dec), .cnt(dt_cnt), .is_zero(dt_zero)
  );

  sdp_down_counter #(.W(TMR_W)) u_ack_wdog (
    .clk(clk), .rst(rst), .load(at_load), .load_val(cfg_atime),
    .dec(at_dec), .cnt(at_cnt), .is_zero(at_zero)
  );

  assign flag_clr = {clr_ato, clr_dto, clr_end};

  sdp_status_flags #(.N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst(rst), .set(flag_set), .clr(flag_clr), .q(flag_q)
  );

  assign flag_end = flag_q[FLAG_END];
  assign flag_dto = flag_q[FLAG_DTO];
  assign flag_ato = flag_q[FLAG_ATO];
  assign state_o  = st_q;

  // R3: the send setup phase lasts one cycle
  a_r3_wait_s_to_send: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_WAIT_S && !err_in) |=> st_q == PH_SEND);
  // R3: outside Idle the byte count never grows
  a_r3_count_monotonic: assert property (@(posedge clk) disable iff (rst)
    (st_q != PH_IDLE) |=> data_cnt <= $past(data_cnt));
  // R8: error aborts the transfer
  a_r8_err_abort: assert property (@(posedge clk) disable iff (rst)
    (st_q != PH_IDLE && err_in) |=> st_q == PH_IDLE);
  // R6: the data timeout flag only rises from the watched phases
  a_r6_dto_source: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_dto) |-> ($past(st_q) == PH_WAIT_R || $past(st_q) == PH_BUSY));
  // R7: the acknowledgment timeout only rises from WaitAck
  a_r7_ato_source: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_ato) |-> $past(st_q) == PH_WAIT_ACK);
  // R2: a start request outside Idle leaves the byte count alone
  a_r2_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (st_q != PH_IDLE && start_req && !byte_stb) |=> $stable(data_cnt));
endmodule

// File: tb/tb_sd_data_path_ctrl.sv
module tb_sd_data_path_ctrl;
  localparam int LEN_W = 16;
  localparam int TMR_W = 16;
  localparam logic [2:0] S_IDLE = 3'd0, S_WS = 3'd1, S_SEND = 3'd2,
                         S_WR = 3'd3, S_RECV = 3'd4, S_BUSY = 3'd5, S_WACK = 3'd6;

  logic clk = 1'b0, rst = 1'b1;
  logic [LEN_W-1:0] cfg_len = '0;
  logic [TMR_W-1:0] cfg_dtime = 16'd100, cfg_atime = 16'd100;
  logic start_req = 0, start_dir = 0, start_ack = 0, byte_stb = 0;
  logic rx_start_bit = 0, card_busy = 0, ack_rcv = 0, err_in = 0;
  logic clr_end = 0, clr_dto = 0, clr_ato = 0;
  logic [LEN_W-1:0] data_cnt;
  logic flag_end, flag_dto, flag_ato;
  logic [2:0] state_o;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  sd_data_path_ctrl #(.LEN_W(LEN_W), .TMR_W(TMR_W)) dut (
    .clk, .rst, .cfg_len, .cfg_dtime, .cfg_atime, .start_req, .start_dir,
    .start_ack, .byte_stb, .rx_start_bit, .card_busy, .ack_rcv, .err_in,
    .clr_end, .clr_dto, .clr_ato, .data_cnt, .flag_end, .flag_dto,
    .flag_ato, .state_o
  );

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_all;
    clr_end = 1; clr_dto = 1; clr_ato = 1;
    tick;
    clr_end = 0; clr_dto = 0; clr_ato = 0;
  endtask

  // Row: dir[17] ack[16] len[15:8] busy_cycles[7:0]
  localparam int NVEC = 5;
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'd4, 8'd0},
    {1'b0, 1'b0, 8'd3, 8'd5},
    {1'b1, 1'b0, 8'd5, 8'd0},
    {1'b1, 1'b1, 8'd2, 8'd0},
    {1'b0, 1'b1, 8'd1, 8'd1}
  };

  task automatic run_xfer(input logic dir, input logic ack, input int len, input int busy);
    cfg_len = LEN_W'(len); start_dir = dir; start_ack = ack; start_req = 1;
    tick;
    start_req = 0;
    chk("R2 phase after start", state_o, dir ? S_WR : S_WS);
    chk("R2 count loaded", data_cnt, len);
    if (!dir) begin
      tick;
      chk("R3 WaitSend to Send", state_o, S_SEND);
    end else begin
      rx_start_bit = 1;
      tick;
      rx_start_bit = 0;
      chk("R5 start bit to Receive", state_o, S_RECV);
    end
    for (int i = 0; i < len; i++) begin
      tick;
      chk("R3 count holds without strobe", data_cnt, len - i);
      byte_stb = 1;
      if (!dir && i == len - 1) card_busy = (busy > 0);
      tick;
      byte_stb = 0;
      chk("R3 count after strobe", data_cnt, len - 1 - i);
    end
    if (!dir && busy > 0) begin
      chk("R4 enters Busy", state_o, S_BUSY);
      for (int b = 1; b < busy; b++) tick;
      chk("R4 still Busy", state_o, S_BUSY);
      card_busy = 0;
      tick;
    end else if (dir && ack) begin
      chk("R7 enters WaitAck", state_o, S_WACK);
      tick;
      tick;
      chk("R7 waits for ack", state_o, S_WACK);
      ack_rcv = 1;
      tick;
      ack_rcv = 0;
    end
    chk("R4 R5 R7 back to Idle", state_o, S_IDLE);
    chk("R4 R5 R7 end flag", flag_end, 1);
    chk("R6 no data timeout", flag_dto, 0);
    chk("R7 no ack timeout", flag_ato, 0);
    clr_end = 1;
    tick;
    clr_end = 0;
    chk("R9 clear pulse", flag_end, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick; tick;
    rst = 0;
    // R1 reset state
    chk("R1 reset phase", state_o, S_IDLE);
    chk("R1 reset count", data_cnt, 0);
    chk("R1 reset flags", {flag_end, flag_dto, flag_ato}, 0);

    for (int v = 0; v < NVEC; v++)
      run_xfer(VEC[v][17], VEC[v][16], int'(VEC[v][15:8]), int'(VEC[v][7:0]));

    // R2 start ignored outside Idle
    cfg_len = 16'd3; start_dir = 0; start_ack = 0; start_req = 1;
    tick; start_req = 0; tick;
    chk("R2 in Send", state_o, S_SEND);
    cfg_len = 16'd9; start_dir = 1; start_req = 1;
    tick; start_req = 0;
    chk("R2 ignored start keeps phase", state_o, S_SEND);
    chk("R2 ignored start keeps count", data_cnt, 3);
    // R8 error abort from Send
    err_in = 1;
    tick; err_in = 0;
    chk("R8 abort to Idle", state_o, S_IDLE);
    chk("R8 no end flag", flag_end, 0);

    // R6 data timeout in WaitRecv, N=3
    cfg_dtime = 16'd3; cfg_len = 16'd2; start_dir = 1; start_req = 1;
    tick; start_req = 0;
    for (int k = 0; k < 3; k++) begin
      tick;
      chk("R6 still WaitRecv", state_o, S_WR);
    end
    tick;
    chk("R6 timeout to Idle", state_o, S_IDLE);
    chk("R6 dto flag", flag_dto, 1);
    chk("R6 end suppressed", flag_end, 0);
    clear_all;
    chk("R9 dto cleared", flag_dto, 0);

    // R6 busy timeout, N=2, reload on entering Busy
    cfg_dtime = 16'd2; cfg_len = 16'd1; start_dir = 0; start_req = 1;
    tick; start_req = 0;
    repeat (4) tick;
    byte_stb = 1; card_busy = 1;
    tick; byte_stb = 0;
    chk("R4 Busy after send", state_o, S_BUSY);
    tick; tick;
    chk("R6 still Busy", state_o, S_BUSY);
    tick;
    chk("R6 busy timeout", state_o, S_IDLE);
    chk("R6 busy dto flag", flag_dto, 1);
    chk("R6 busy end suppressed", flag_end, 0);
    card_busy = 0;
    clear_all;

    // R7 ack timeout, M=2
    cfg_dtime = 16'd100; cfg_atime = 16'd2; cfg_len = 16'd1;
    start_dir = 1; start_ack = 1; start_req = 1;
    tick; start_req = 0;
    rx_start_bit = 1; tick; rx_start_bit = 0;
    byte_stb = 1; tick; byte_stb = 0;
    chk("R7 WaitAck", state_o, S_WACK);
    tick; tick;
    chk("R7 still WaitAck", state_o, S_WACK);
    tick;
    chk("R7 ack timeout to Idle", state_o, S_IDLE);
    chk("R7 ato flag", flag_ato, 1);
    chk("R7 end suppressed", flag_end, 0);
    clear_all;
    chk("R9 ato cleared", flag_ato, 0);

    // R8 error during Receive
    start_ack = 0; cfg_len = 16'd4; start_req = 1;
    tick; start_req = 0;
    rx_start_bit = 1; tick; rx_start_bit = 0;
    byte_stb = 1; tick; byte_stb = 0;
    err_in = 1; tick; err_in = 0;
    chk("R8 receive abort", state_o, S_IDLE);
    chk("R8 receive no flags", {flag_end, flag_dto, flag_ato}, 0);
    chk("R8 count frozen", data_cnt, 3);

    // R10 zero length, R9 set beats same-cycle clear
    cfg_len = 16'd0; start_dir = 0; start_req = 1; clr_end = 1;
    tick; start_req = 0; clr_end = 0;
    chk("R10 stays Idle", state_o, S_IDLE);
    chk("R10 zero-length end flag", flag_end, 1);
    chk("R9 set wins over clear", flag_end, 1);
    tick;
    chk("R9 flag sticky", flag_end, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule